// File: doc/BRIEF.md
# Serial Control Word Loader

This block is a three-wire serial load port. It has a serial clock, a serial data line and a load strobe. It collects a 24-bit control word and commits it to one of four parallel control registers. The word arrives most significant bit first, and one bit is captured on each rising serial clock edge. A rising edge on the load strobe commits the most recent 24 bits to a register. The two least significant bits of the word choose which register.

The four registers are:
- a reference divider value;
- a pair of feedback divider values, a 6-bit swallow count and a 13-bit main count;
- a function settings word;
- an initialization settings word.

All three serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and edges are detected in the system clock domain. A one-cycle strobe reports which register was just written. A separate one-cycle pulse marks an initialization write, which downstream dividers use to restart.

Top module: `ser_ctl_port`

## Requirements
- R1: After reset every register output, the update strobe and the counter-restart pulse are all zero.
- R2: Each rising serial clock edge shifts the data bit into the least significant end of a 24-bit register. Only the last 24 bits before a commit count, so bits sent earlier are discarded.
- R3: A rising load-strobe edge commits the shift register. Bits [1:0] pick the target: 2'b00 reference divider, 2'b01 feedback dividers, 2'b10 function word, 2'b11 initialization word.
- R4: A reference-divider write takes its 14-bit value from bits [15:2], and any value from 1 to 16383 is stored. Bits [23:16] are ignored.
- R5: A reference-divider write whose value is 0 is rejected. The previous value is kept and no update strobe is produced.
- R6: A feedback-divider write loads the swallow count from bits [7:2] (0 to 63) and the main count from bits [20:8]. Bits [23:21] are ignored.
- R7: A function write loads bits [23:2] into the 22-bit function output.
- R8: An initialization write loads bits [23:2] into both the initialization output and the function output. It also raises the counter-restart output for exactly the cycle of the update strobe.
- R9: Each accepted write raises exactly one update-strobe bit for one cycle. The bit index equals the address code. Registers that were not addressed keep their values.
- R10: Serial clock edges without a load-strobe edge change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe, commit on rising edge |
| r_div_o | output | 14 | Reference divider value |
| a_cnt_o | output | 6 | Swallow count |
| b_cnt_o | output | 13 | Main count |
| func_o | output | 22 | Function settings payload |
| init_o | output | 22 | Initialization settings payload |
| upd_o | output | 4 | One-hot update strobe, index equals address code |
| cnt_rst_o | output | 1 | One-cycle counter-restart pulse on initialization write |

## Verification
The bound checker watches several properties on every cycle:
- the update strobe is one-hot and lasts a single cycle;
- the restart pulse coincides exactly with an initialization strobe;
- a register that was not addressed never changes;
- once the reference divider is nonzero, it stays nonzero.

Other properties can only be shown by the bench's scenarios with a scoreboard of expected writes:
- the MSB-first bit order and the field positions;
- discarding of surplus leading bits;
- rejection of a zero reference value;
- silence when the serial clock toggles without a commit.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
    localparam int ADDR_W = 2;
    localparam int N_LATCH = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_RDIV = 2'b00,
        SEL_NDIV = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } latch_sel_e;
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    assign st_d[0] = d_i;
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign st_d[g] = st_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ser_ctl_edge.sv
module ser_ctl_edge #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/ser_ctl_shreg.sv
module ser_ctl_shreg #(
    parameter int FRAME_W = 24
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               shift_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] word_o
);
    logic [FRAME_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift_i) word_d = {word_q[FRAME_W-2:0], bit_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) word_q <= '0;
        else         word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/ser_ctl_port.sv
module ser_ctl_port
    import ser_ctl_pkg::*;
#(
    parameter int FRAME_W     = 24,
    parameter int R_W         = 14,
    parameter int A_W         = 6,
    parameter int B_W         = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      ser_clk_i,
    input  logic                      ser_dat_i,
    input  logic                      ser_le_i,
    output logic [R_W-1:0]            r_div_o,
    output logic [A_W-1:0]            a_cnt_o,
    output logic [B_W-1:0]            b_cnt_o,
    output logic [FRAME_W-ADDR_W-1:0] func_o,
    output logic [FRAME_W-ADDR_W-1:0] init_o,
    output logic [N_LATCH-1:0]        upd_o,
    output logic                      cnt_rst_o
);
    localparam int PAY_W = FRAME_W - ADDR_W;
    localparam int R_LO  = ADDR_W;
    localparam int A_LO  = ADDR_W;
    localparam int B_LO  = ADDR_W + A_W;

    typedef struct packed {
        logic [R_W-1:0]     rdiv;
        logic [A_W-1:0]     acnt;
        logic [B_W-1:0]     bcnt;
        logic [PAY_W-1:0]   func;
        logic [PAY_W-1:0]   init;
        logic [N_LATCH-1:0] upd;
        logic               cnt_rst;
    } regs_t;

    logic [2:0]         sync_lvl;
    logic [1:0]         rise;
    logic [FRAME_W-1:0] frame;
    regs_t              st_d, st_q;

    // sync_lvl: [2] load strobe, [1] data, [0] serial clock
    ser_ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({ser_le_i, ser_dat_i, ser_clk_i}),
        .q_o    (sync_lvl)
    );

    ser_ctl_edge #(.W(2)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  ({sync_lvl[2], sync_lvl[0]}),
        .rise_o (rise)
    );

    ser_ctl_shreg #(.FRAME_W(FRAME_W)) u_shreg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (rise[0]),
        .bit_i   (sync_lvl[1]),
        .word_o  (frame)
    );

    always_comb begin
        logic [R_W-1:0] r_new;
        r_new      = frame[R_LO +: R_W];
        st_d       = st_q;
        st_d.upd   = '0;
        st_d.cnt_rst = 1'b0;
        if (rise[1]) begin
            unique case (latch_sel_e'(frame[ADDR_W-1:0]))
                SEL_RDIV: begin
                    if (r_new != '0) begin
                        st_d.rdiv = r_new;
                        st_d.upd[SEL_RDIV] = 1'b1;
                    end
                end
                SEL_NDIV: begin
                    st_d.acnt = frame[A_LO +: A_W];
                    st_d.bcnt = frame[B_LO +: B_W];
                    st_d.upd[SEL_NDIV] = 1'b1;
                end
                SEL_FUNC: begin
                    st_d.func = frame[FRAME_W-1:ADDR_W];
                    st_d.upd[SEL_FUNC] = 1'b1;
                end
                SEL_INIT: begin
                    st_d.init    = frame[FRAME_W-1:ADDR_W];
                    st_d.func    = frame[FRAME_W-1:ADDR_W];
                    st_d.upd[SEL_INIT] = 1'b1;
                    st_d.cnt_rst = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign r_div_o   = st_q.rdiv;
    assign a_cnt_o   = st_q.acnt;
    assign b_cnt_o   = st_q.bcnt;
    assign func_o    = st_q.func;
    assign init_o    = st_q.init;
    assign upd_o     = st_q.upd;
    assign cnt_rst_o = st_q.cnt_rst;
endmodule

// File: rtl/ser_ctl_port_chk.sv
module ser_ctl_port_chk #(
    parameter int PAY_W = 22,
    parameter int R_W   = 14,
    parameter int A_W   = 6,
    parameter int B_W   = 13
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [R_W-1:0]   r_div_o,
    input logic [A_W-1:0]   a_cnt_o,
    input logic [B_W-1:0]   b_cnt_o,
    input logic [PAY_W-1:0] func_o,
    input logic [PAY_W-1:0] init_o,
    input logic [3:0]       upd_o,
    input logic             cnt_rst_o
);
    p_strobe_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(upd_o));

    p_strobe_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_o != 4'b0) |=> (upd_o == 4'b0));

    p_restart_on_init_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_rst_o |-> upd_o[3]);

    p_init_has_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_o[3] |-> cnt_rst_o);

    p_rdiv_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(r_div_o) != '0) |-> (r_div_o != '0));

    p_rdiv_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_o[0] |-> $stable(r_div_o));

    p_ndiv_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_o[1] |-> ($stable(a_cnt_o) && $stable(b_cnt_o)));

    p_func_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(upd_o[2] || upd_o[3]) |-> $stable(func_o));

    p_init_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_o[3] |-> $stable(init_o));
endmodule

bind ser_ctl_port ser_ctl_port_chk #(
    .PAY_W (FRAME_W - 2),
    .R_W   (R_W),
    .A_W   (A_W),
    .B_W   (B_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .r_div_o   (r_div_o),
    .a_cnt_o   (a_cnt_o),
    .b_cnt_o   (b_cnt_o),
    .func_o    (func_o),
    .init_o    (init_o),
    .upd_o     (upd_o),
    .cnt_rst_o (cnt_rst_o)
);

// File: tb/ser_ctl_port_test.sv
module ser_ctl_port_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic [13:0] r_div;
    logic [5:0]  a_cnt;
    logic [12:0] b_cnt;
    logic [21:0] func, init;
    logic [3:0]  upd;
    logic        cnt_rst;

    int n_chk = 0, n_fail = 0, n_strobe = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [1:0]  sel;
        logic [13:0] r;
        logic [5:0]  a;
        logic [12:0] b;
        logic [21:0] f;
        logic [21:0] i;
    } exp_t;

    exp_t q[$];
    logic [13:0] m_r = '0;
    logic [5:0]  m_a = '0;
    logic [12:0] m_b = '0;
    logic [21:0] m_f = '0, m_i = '0;

    always #10 clk = ~clk;

    ser_ctl_port uut (
        .clk_i(clk), .rst_ni(rst_n),
        .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
        .r_div_o(r_div), .a_cnt_o(a_cnt), .b_cnt_o(b_cnt),
        .func_o(func), .init_o(init), .upd_o(upd), .cnt_rst_o(cnt_rst)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int nbits);
        for (int k = nbits - 1; k >= 0; k--) begin
            sdat = w[k];
            wait_cyc(3);
            sclk = 1'b1;
            wait_cyc(3);
            sclk = 1'b0;
            wait_cyc(3);
        end
    endtask

    task automatic pulse_le();
        sle = 1'b1;
        wait_cyc(6);
        sle = 1'b0;
        wait_cyc(6);
    endtask

    // model from requirements: R3..R8
    task automatic send(input logic [31:0] w, input int nbits);
        logic [23:0] fr;
        exp_t e;
        fr = w[23:0];
        shift_bits(w, nbits);
        case (fr[1:0])
            2'b00: if (fr[15:2] != 0) begin m_r = fr[15:2]; e.sel = 2'b00; end
            2'b01: begin m_a = fr[7:2]; m_b = fr[20:8]; e.sel = 2'b01; end
            2'b10: begin m_f = fr[23:2]; e.sel = 2'b10; end
            default: begin m_f = fr[23:2]; m_i = fr[23:2]; e.sel = 2'b11; end
        endcase
        if (!(fr[1:0] == 2'b00 && fr[15:2] == 0)) begin
            e.r = m_r; e.a = m_a; e.b = m_b; e.f = m_f; e.i = m_i;
            q.push_back(e);
        end
        pulse_le();
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (upd != 4'b0) begin
                n_strobe++;
                if (q.size() == 0) begin
                    chk(1'b0, "R9 unexpected strobe", upd, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(upd == (4'b1 << e.sel), "R3/R9 strobe select", upd, 4'b1 << e.sel);
                    chk(cnt_rst == (e.sel == 2'b11), "R8 restart pulse", cnt_rst, e.sel == 2'b11);
                    chk(r_div == e.r, "R4 reference divider", r_div, e.r);
                    chk(a_cnt == e.a, "R6 swallow count", a_cnt, e.a);
                    chk(b_cnt == e.b, "R6 main count", b_cnt, e.b);
                    chk(func == e.f, "R7 function word", func, e.f);
                    chk(init == e.i, "R8 init word", init, e.i);
                end
            end else if (cnt_rst) begin
                chk(1'b0, "R8 restart without strobe", cnt_rst, 0);
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int s0;
        wait_cyc(4);
        // R1 reset state
        chk(r_div == 0, "R1 r_div", r_div, 0);
        chk(a_cnt == 0 && b_cnt == 0, "R1 n_div", {a_cnt, b_cnt}, 0);
        chk(func == 0 && init == 0, "R1 payloads", {func, init}, 0);
        chk(upd == 0 && cnt_rst == 0, "R1 strobes", {upd, cnt_rst}, 0);
        rst_n = 1'b1;
        wait_cyc(4);

        send({8'h00, 8'hA5, 14'd1, 2'b00}, 24);          // R4 min
        send({8'h00, 8'h5A, 14'd16383, 2'b00}, 24);      // R4 max, upper bits ignored
        send({8'h00, 3'b101, 13'd3, 6'd0, 2'b01}, 24);   // R6
        send({8'h00, 3'b010, 13'd8191, 6'd63, 2'b01}, 24);
        send({8'h00, 22'h2AAAAA, 2'b10}, 24);            // R7
        send({8'h00, 22'h155555, 2'b11}, 24);            // R8

        // R5: zero reference value rejected
        s0 = n_strobe;
        send({8'h00, 8'hFF, 14'd0, 2'b00}, 24);
        wait_cyc(4);
        chk(r_div == 14'd16383, "R5 zero rejected, value kept", r_div, 14'd16383);
        chk(n_strobe == s0, "R5 no strobe on zero", n_strobe, s0);

        // R10: serial clocks without load strobe
        s0 = n_strobe;
        shift_bits({8'h00, 22'h3FFFFF, 2'b10}, 24);
        wait_cyc(6);
        chk(n_strobe == s0, "R10 no strobe without commit", n_strobe, s0);
        chk(func == 22'h155555, "R10 function unchanged", func, 22'h155555);

        // R2: 28-bit burst, leading 4 bits discarded; order check
        send({4'hF, 22'h000001, 2'b10, 4'h0} >> 4 | 32'hF000_0000, 28);
        send({4'h0, 2'b10, 14'h1234 ^ 14'h0, 8'h0} >> 8, 24); // R2 R4 rejection path not used
        send({8'h00, 8'h00, 14'h2C3D, 2'b00}, 24);       // R2 bit order in R field
        send({8'h00, 22'h3C0F0F, 2'b11}, 24);            // R8 again
        send({8'h00, 22'h000F00, 2'b10}, 24);            // R9 func only, init kept

        wait_cyc(20);
        chk(q.size() == 0, "R3 all commits observed", q.size(), 0);
        chk(r_div == m_r && func == m_f && init == m_i, "R9 final state",
            {r_div, func}, {m_r, m_f});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule